// File: doc/BRIEF.md
# Card Data FIFO Engine

This block moves the data phase of a memory-card transfer between a byte-wide card port and a pair of byte FIFOs that the host reaches through a 1-, 2- or 4-byte access port. When a transfer starts, the engine loads a countdown with the block length times the block count. A direction flag then chooses the path. Sending to the card drains the transmit FIFO onto a valid/ready byte stream. Receiving from the card fills the receive FIFO from another valid/ready byte stream.

The host keeps data flowing by answering two service requests. The transmit request asks the host for more bytes, and the receive request tells it that bytes have arrived. When the countdown runs out, the engine reports completion through a data-done flag and, for transfers toward the card, a program-done flag.

A flush command throws away a partly filled transmit buffer and moves filling to the other half of the transmit storage. A stop command ends the transfer at once. Multi-byte host accesses carry the earliest FIFO byte in the most significant byte lane.

Top module: `card_fifo_engine`

## Requirements
- R1: While reset is held, busy, tx_req, rx_req, data_done, prog_done, card_tx_valid and card_rx_ready are all 0.
- R2: A start loads a countdown of xfer_blk_len × xfer_blk_cnt bytes and sets busy. Exactly that many bytes cross the card port. On the edge after the last byte moves, busy falls and data_done rises.
- R3: With xfer_to_card = 1 the transmit FIFO drains in order onto card_tx_data. With xfer_to_card = 0 the receive FIFO fills from card_rx_data, and the host reads those bytes back in the order they arrived.
- R4: card_tx_valid is high only while bytes remain and the transmit FIFO is not empty, and at most one byte moves per cycle. tx_req sets when bytes remain but the transmit FIFO is empty. Any host write clears tx_req.
- R5: card_rx_ready is high only while bytes remain and the receive FIFO holds fewer than DEPTH (32) bytes. Each stored byte sets rx_req. A host read clears rx_req, except in a cycle where a byte is stored, when it stays set.
- R6: A transfer toward the card also sets prog_done at completion. A transfer from the card leaves prog_done at 0.
- R7: host_size 0, 1 and 2 (3 acts as 2) move 1, 2 and 4 bytes. In an N-byte access the first FIFO byte sits in bits [8N-1:8N-8] and later bytes fill the lower lanes. host_rdata bits above 8N are 0.
- R8: A host read stops early when the receive FIFO empties, and the lanes it did not fill read 0. A host write stops when the transmit FIFO is full, and its extra bytes never reach the card.
- R9: A part_flush pulse discards every byte in the transmit FIFO, and none of them appears on the card port. Bytes written afterwards are sent normally.
- R10: clk_stop forces card_tx_valid and card_rx_ready to 0 in the same cycle and clears busy on the next edge, without setting data_done.
- R11: A start with a zero byte count never opens the card port and completes on the second edge after the start.
- R12: A start empties both FIFOs and clears data_done, prog_done, tx_req and rx_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start pulse; loads the countdown and the direction |
| xfer_blk_len | input | 12 | Block length in bytes |
| xfer_blk_cnt | input | 16 | Number of blocks |
| xfer_to_card | input | 1 | 1: send to card, 0: receive from card |
| clk_stop | input | 1 | Stop pulse; ends the transfer at once |
| part_flush | input | 1 | Discards the transmit contents and switches buffer half |
| host_wr | input | 1 | Host write into the transmit FIFO |
| host_rd | input | 1 | Host read from the receive FIFO |
| host_size | input | 2 | Access width code: 0 byte, 1 halfword, 2/3 word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Packed receive data for the current access |
| card_tx_valid | output | 1 | Byte available toward the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| card_tx_data | output | 8 | Byte toward the card |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_ready | output | 1 | Engine accepts a card byte |
| card_rx_data | input | 8 | Byte from the card |
| busy | output | 1 | Transfer in progress |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| data_done | output | 1 | Data phase complete |
| prog_done | output | 1 | Program phase complete (transfers to the card) |

## Verification
The receive path has a same-cycle case: the card can store a byte in the very cycle the host reads the FIFO, so a set and a clear of rx_req meet on one edge. The bench fills the receive FIFO to its limit so that the card is held off. It then reads one word, which reopens room, and reads again while the card is offering a byte. After that edge rx_req must still be high. A scoreboard confirms that the popped bytes and the newly stored byte keep their arrival order.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_WORD2 = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic data_done;
        logic prog_done;
        logic tx_req;
        logic rx_req;
    } xfer_flags_t;

    localparam int LANES = 4;

    function automatic logic [2:0] acc_bytes(acc_size_e s);
        case (s)
            ACC_BYTE: return 3'd1;
            ACC_HALF: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    // byte k of an n-byte access, counted from the most significant lane
    function automatic logic [7:0] lane_get(logic [31:0] w, logic [2:0] n, int k);
        int sh;
        sh = (int'(n) - 1 - k) * 8;
        if (sh < 0) return 8'h00;
        return 8'(w >> sh);
    endfunction

    function automatic logic [31:0] lane_put(logic [7:0] b, logic [2:0] n, int k);
        int sh;
        sh = (int'(n) - 1 - k) * 8;
        if (sh < 0) return 32'h0;
        return 32'(b) << sh;
    endfunction

endpackage

// File: rtl/cdf_tx_buf.sv
module cdf_tx_buf import cdf_pkg::*; #(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          flip,
    input  logic          wr_en,
    input  acc_size_e     wr_size,
    input  logic [31:0]   wr_data,
    input  logic          pop,
    output logic [PW:0]   level,
    output logic [7:0]    head
);
    logic [7:0]    mem [2*DEPTH];
    logic          half_q;
    logic [PW-1:0] rd_ptr_q;
    logic [PW:0]   level_q;
    logic [2:0]    n_bytes;
    logic [PW:0]   space;
    logic [PW:0]   take;

    always_comb begin
        n_bytes = acc_bytes(wr_size);
        space   = (PW+1)'(DEPTH) - level_q;
        take    = (space < (PW+1)'(n_bytes)) ? space : (PW+1)'(n_bytes);
    end

    assign head  = mem[{half_q, rd_ptr_q}];
    assign level = level_q;

    always_ff @(posedge clk) begin
        if (wr_en && !clear && !flip) begin
            for (int k = 0; k < LANES; k++) begin
                if (k < int'(take))
                    mem[{half_q, PW'(rd_ptr_q + level_q[PW-1:0] + PW'(k))}] <= lane_get(wr_data, n_bytes, k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q   <= 1'b0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else if (clear || flip) begin
            rd_ptr_q <= '0;
            level_q  <= '0;
            if (flip) half_q <= ~half_q;
        end else begin
            rd_ptr_q <= rd_ptr_q + PW'(pop);
            level_q  <= level_q + (wr_en ? take : '0) - (PW+1)'(pop);
        end
    end

    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (level_q != '0));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        level_q <= (PW+1)'(DEPTH));

endmodule

// File: rtl/cdf_rx_buf.sv
module cdf_rx_buf import cdf_pkg::*; #(
    parameter int DEPTH = 32,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          rd_en,
    input  acc_size_e     rd_size,
    output logic [PW:0]   level,
    output logic [31:0]   rd_data
);
    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_ptr_q;
    logic [PW:0]   level_q;
    logic [2:0]    n_bytes;
    logic [PW:0]   take;

    always_comb begin
        n_bytes = acc_bytes(rd_size);
        take    = (level_q < (PW+1)'(n_bytes)) ? level_q : (PW+1)'(n_bytes);
        rd_data = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(take))
                rd_data = rd_data | lane_put(mem[PW'(rd_ptr_q + PW'(k))], n_bytes, k);
        end
    end

    assign level = level_q;

    always_ff @(posedge clk) begin
        if (push && !clear)
            mem[PW'(rd_ptr_q + level_q[PW-1:0])] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            rd_ptr_q <= rd_ptr_q + (rd_en ? take[PW-1:0] : '0);
            level_q  <= level_q + (PW+1)'(push) - (rd_en ? take : '0);
        end
    end

    p_push_room_r5: assert property (@(posedge clk) disable iff (rst)
        push |-> (level_q < (PW+1)'(DEPTH)));

endmodule

// File: rtl/cdf_xfer_ctl.sv
module cdf_xfer_ctl import cdf_pkg::*; #(
    parameter int DEPTH = 32,
    parameter int LEN_W = 12,
    parameter int CNT_W = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int LEFT_W = LEN_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [CNT_W-1:0] blk_cnt,
    input  logic             to_card,
    input  logic             stop,
    input  logic [PW:0]      tx_level,
    input  logic [PW:0]      rx_level,
    input  logic             card_tx_ready,
    input  logic             card_rx_valid,
    input  logic             host_wr,
    input  logic             host_rd,
    output logic             busy,
    output logic             card_tx_valid,
    output logic             card_rx_ready,
    output logic             tx_pop,
    output logic             rx_push,
    output xfer_flags_t      flags
);
    logic              busy_q;
    logic              dir_q;
    logic [LEFT_W-1:0] left_q;
    xfer_flags_t       flags_q;
    logic              go;
    logic              more;

    assign go            = busy_q && !stop && !start;
    assign more          = (left_q != '0);
    assign card_tx_valid = go && dir_q && more && (tx_level != '0);
    assign card_rx_ready = go && !dir_q && more && (rx_level < (PW+1)'(DEPTH));
    assign tx_pop        = card_tx_valid && card_tx_ready;
    assign rx_push       = card_rx_valid && card_rx_ready;
    assign busy          = busy_q;
    assign flags         = flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            dir_q   <= 1'b0;
            left_q  <= '0;
            flags_q <= '0;
        end else begin
            if (stop) begin
                busy_q <= 1'b0;
            end else if (start) begin
                busy_q  <= 1'b1;
                dir_q   <= to_card;
                left_q  <= LEFT_W'(blk_len) * LEFT_W'(blk_cnt);
            end else if (busy_q) begin
                if (!more) begin
                    busy_q            <= 1'b0;
                    flags_q.data_done <= 1'b1;
                    if (dir_q) flags_q.prog_done <= 1'b1;
                end else if (tx_pop || rx_push) begin
                    left_q <= left_q - 1'b1;
                end
            end

            if (start && !stop) begin
                flags_q <= '0;
            end else begin
                if (host_wr)
                    flags_q.tx_req <= 1'b0;
                else if (go && dir_q && more && tx_level == '0)
                    flags_q.tx_req <= 1'b1;
                if (rx_push)
                    flags_q.rx_req <= 1'b1;
                else if (host_rd)
                    flags_q.rx_req <= 1'b0;
            end
        end
    end

    p_stop_idles_r10: assert property (@(posedge clk) disable iff (rst)
        stop |=> !busy_q);
    p_prog_with_data_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.prog_done) |-> (flags_q.data_done && dir_q));
    p_rx_req_store_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_push && !start) |=> flags_q.rx_req);
    p_done_after_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !more && !stop && !start) |=> (!busy_q && flags_q.data_done));
    p_start_clears_r12: assert property (@(posedge clk) disable iff (rst)
        (start && !stop) |=> (busy_q && !flags_q.data_done && !flags_q.prog_done));

endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine import cdf_pkg::*; #(
    parameter int DEPTH = 32,
    parameter int LEN_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_start,
    input  logic [LEN_W-1:0] xfer_blk_len,
    input  logic [CNT_W-1:0] xfer_blk_cnt,
    input  logic             xfer_to_card,
    input  logic             clk_stop,
    input  logic             part_flush,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_size,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    output logic             card_tx_valid,
    input  logic             card_tx_ready,
    output logic [7:0]       card_tx_data,
    input  logic             card_rx_valid,
    output logic             card_rx_ready,
    input  logic [7:0]       card_rx_data,
    output logic             busy,
    output logic             tx_req,
    output logic             rx_req,
    output logic             data_done,
    output logic             prog_done
);
    localparam int PW = $clog2(DEPTH);

    logic [PW:0]  tx_level;
    logic [PW:0]  rx_level;
    logic         tx_pop;
    logic         rx_push;
    xfer_flags_t  flags;
    acc_size_e    size_e;
    logic         start_eff;

    assign size_e    = acc_size_e'(host_size);
    assign start_eff = xfer_start && !clk_stop;

    cdf_xfer_ctl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) ctl_i (
        .clk, .rst,
        .start(xfer_start), .blk_len(xfer_blk_len), .blk_cnt(xfer_blk_cnt),
        .to_card(xfer_to_card), .stop(clk_stop),
        .tx_level, .rx_level, .card_tx_ready, .card_rx_valid,
        .host_wr, .host_rd,
        .busy, .card_tx_valid, .card_rx_ready, .tx_pop, .rx_push, .flags
    );

    cdf_tx_buf #(.DEPTH(DEPTH)) tx_i (
        .clk, .rst, .clear(start_eff), .flip(part_flush),
        .wr_en(host_wr), .wr_size(size_e), .wr_data(host_wdata),
        .pop(tx_pop), .level(tx_level), .head(card_tx_data)
    );

    cdf_rx_buf #(.DEPTH(DEPTH)) rx_i (
        .clk, .rst, .clear(start_eff), .push(rx_push), .push_data(card_rx_data),
        .rd_en(host_rd), .rd_size(size_e), .level(rx_level), .rd_data(host_rdata)
    );

    assign tx_req    = flags.tx_req;
    assign rx_req    = flags.rx_req;
    assign data_done = flags.data_done;
    assign prog_done = flags.prog_done;

endmodule

// File: tb/card_fifo_engine_tb_top.sv
module card_fifo_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        xfer_start, xfer_to_card, clk_stop, part_flush;
    logic [11:0] xfer_blk_len;
    logic [15:0] xfer_blk_cnt;
    logic        host_wr, host_rd;
    logic [1:0]  host_size;
    logic [31:0] host_wdata, host_rdata;
    logic        card_tx_valid, card_tx_ready;
    logic [7:0]  card_tx_data;
    logic        card_rx_valid, card_rx_ready;
    logic [7:0]  card_rx_data;
    logic        busy, tx_req, rx_req, data_done, prog_done;

    int total = 0;
    int bad = 0;
    int tx_moved = 0;
    int m0;
    bit finished = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #10 clk = ~clk;

    card_fifo_engine dut_i (.*);

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int nbytes(logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // transmit monitor: scoreboard pop on every card handshake
    initial forever begin
        @(negedge clk); #2;
        if (card_tx_valid && card_tx_ready) begin
            tx_moved++;
            if (txq.size() == 0) begin
                total++; bad++;
                $display("FAIL R9 unexpected card byte actual=%h expected=none", card_tx_data);
            end else begin
                chk("R3", "card byte order", 32'(card_tx_data), 32'(txq.pop_front()));
            end
        end
    end

    // card source: pushes each accepted byte to the scoreboard
    initial forever begin
        @(negedge clk); #2;
        if (card_rx_valid && card_rx_ready) begin
            rxq.push_back(card_rx_data);
            @(posedge clk); #1;
            card_rx_data = card_rx_data + 8'h07;
        end
    end

    task automatic start_xfer(logic [11:0] len, logic [15:0] cnt, logic to);
        xfer_blk_len = len; xfer_blk_cnt = cnt; xfer_to_card = to; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic host_write(logic [1:0] sz, logic [31:0] v, int keep);
        int nb;
        nb = nbytes(sz);
        host_wr = 1'b1; host_size = sz; host_wdata = v;
        for (int i = 0; i < keep; i++) txq.push_back(8'(v >> (8 * (nb - 1 - i))));
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(logic [1:0] sz, string req);
        int nb, take;
        logic [31:0] exp;
        nb = nbytes(sz);
        host_rd = 1'b1; host_size = sz;
        #1;
        take = (rxq.size() < nb) ? rxq.size() : nb;
        exp = '0;
        for (int i = 0; i < take; i++) exp = exp | (32'(rxq.pop_front()) << (8 * (nb - 1 - i)));
        chk(req, "host read packing", host_rdata, exp);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_done(int max);
        for (int i = 0; i < max && !data_done; i++) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; xfer_start = 0; xfer_to_card = 0; clk_stop = 0; part_flush = 0;
        xfer_blk_len = 0; xfer_blk_cnt = 0; host_wr = 0; host_rd = 0; host_size = 0;
        host_wdata = 0; card_tx_ready = 0; card_rx_valid = 0; card_rx_data = 8'h10;
        repeat (2) @(negedge clk);
        chk("R1", "busy in reset", 32'(busy), 0);
        chk("R1", "requests in reset", {30'd0, tx_req, rx_req}, 0);
        chk("R1", "done flags in reset", {30'd0, data_done, prog_done}, 0);
        chk("R1", "card port in reset", {30'd0, card_tx_valid, card_rx_ready}, 0);
        rst = 1'b0;
        @(negedge clk);

        // write of 2 x 4 bytes with mixed access widths
        card_tx_ready = 1'b1;
        start_xfer(12'd4, 16'd2, 1'b1);
        chk("R2", "busy after start", 32'(busy), 1);
        @(negedge clk);
        chk("R4", "tx_req on empty fifo", 32'(tx_req), 1);
        host_write(2'd2, 32'h11223344, 4);
        chk("R4", "tx_req cleared by write", 32'(tx_req), 0);
        host_write(2'd1, 32'h00005566, 2);
        host_write(2'd0, 32'h00000077, 1);
        host_write(2'd0, 32'h00000088, 1);
        wait_done(40);
        chk("R2", "data_done after write", 32'(data_done), 1);
        chk("R2", "busy low after write", 32'(busy), 0);
        chk("R6", "prog_done after write", 32'(prog_done), 1);
        chk("R2", "bytes moved to card", 32'(tx_moved), 8);
        chk("R3", "tx scoreboard drained", 32'(txq.size()), 0);

        // read of 2 x 3 bytes
        card_rx_valid = 1'b1;
        start_xfer(12'd3, 16'd2, 1'b0);
        chk("R12", "flags cleared by start", {30'd0, data_done, prog_done}, 0);
        wait_done(40);
        chk("R3", "data_done after read", 32'(data_done), 1);
        chk("R6", "no prog_done on read", 32'(prog_done), 0);
        chk("R5", "rx_req after stores", 32'(rx_req), 1);
        host_read(2'd2, "R7");
        chk("R5", "rx_req cleared by read", 32'(rx_req), 0);
        host_read(2'd2, "R8");
        host_read(2'd0, "R8");

        // receive backpressure and same-cycle store/read
        start_xfer(12'd40, 16'd1, 1'b0);
        repeat (40) @(negedge clk);
        chk("R5", "ready low when full", 32'(card_rx_ready), 0);
        chk("R2", "still busy when full", 32'(busy), 1);
        host_read(2'd2, "R7");
        chk("R5", "rx_req cleared", 32'(rx_req), 0);
        chk("R5", "ready after room", 32'(card_rx_ready), 1);
        host_read(2'd3, "R5");
        chk("R5", "store beats read clear", 32'(rx_req), 1);
        for (int w = 0; w < 8; w++) begin
            repeat (4) @(negedge clk);
            host_read(2'd2, "R7");
        end
        wait_done(20);
        chk("R2", "40-byte read done", 32'(data_done), 1);
        chk("R3", "rx scoreboard drained", 32'(rxq.size()), 0);

        // transmit overflow, flush, stop
        card_rx_valid = 1'b0;
        card_tx_ready = 1'b0;
        start_xfer(12'd64, 16'd1, 1'b1);
        for (int i = 0; i < 8; i++) host_write(2'd2, 32'h20212223 + 32'(i) * 32'h04040404, 4);
        host_write(2'd2, 32'hDEADBEEF, 0);
        m0 = tx_moved;
        card_tx_ready = 1'b1;
        repeat (34) @(negedge clk);
        chk("R8", "only fitting bytes sent", 32'(tx_moved - m0), 32);
        chk("R2", "busy with bytes left", 32'(busy), 1);
        card_tx_ready = 1'b0;
        host_write(2'd2, 32'h01020304, 0);
        part_flush = 1'b1;
        @(negedge clk);
        part_flush = 1'b0;
        host_write(2'd2, 32'h0A0B0C0D, 4);
        m0 = tx_moved;
        card_tx_ready = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9", "bytes after flush", 32'(tx_moved - m0), 4);
        chk("R9", "flush scoreboard drained", 32'(txq.size()), 0);
        card_tx_ready = 1'b0;
        host_write(2'd2, 32'h55555555, 0);
        chk("R10", "valid before stop", 32'(card_tx_valid), 1);
        clk_stop = 1'b1;
        #1;
        chk("R10", "valid gated by stop", 32'(card_tx_valid), 0);
        @(negedge clk);
        clk_stop = 1'b0;
        chk("R10", "busy low after stop", 32'(busy), 0);
        chk("R10", "no data_done on stop", 32'(data_done), 0);
        m0 = tx_moved;
        card_tx_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "no bytes after stop", 32'(tx_moved - m0), 0);

        // zero-length transfer
        card_rx_valid = 1'b1;
        start_xfer(12'd0, 16'd5, 1'b0);
        chk("R11", "port closed on zero count", 32'(card_rx_ready), 0);
        @(negedge clk);
        chk("R11", "zero count done", {30'd0, data_done, busy}, 32'h2);
        card_rx_valid = 1'b0;

        // start empties stale transmit bytes
        card_tx_ready = 1'b0;
        start_xfer(12'd2, 16'd1, 1'b1);
        chk("R12", "fifo emptied by start", 32'(card_tx_valid), 0);
        @(negedge clk);
        chk("R12", "tx_req after start", 32'(tx_req), 1);
        host_write(2'd1, 32'h00005A6B, 2);
        card_tx_ready = 1'b1;
        wait_done(10);
        chk("R12", "done after restart", {30'd0, data_done, prog_done}, 32'h3);
        chk("R12", "restart scoreboard drained", 32'(txq.size()), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule